// File: doc/BRIEF.md
# Multimode Fixed-Point Adder/Subtractor

This block adds or subtracts two signed fractions held in two's complement, with the binary point directly after the sign bit, so every operand lies in [-1, 1). A run-time mode selects what happens when the exact result needs one more bit than the operands have. The result can be clamped, widened by one bit, halved, halved only when needed, or wrapped. When a mode halves the sum, a second select chooses whether the discarded bit is truncated or rounded.

The result port is always one bit wider than the operands. Modes that keep the operand width place their result sign-extended on that port. The halve-on-demand mode also raises a flag in the same cycle it shifts. Logic that tracks a shared exponent for a whole block of data can count these flags. The block itself keeps no exponent. All outputs come from registers, one clock after the operands are presented.

Top module: `fxp_addsub`

## Requirements
- R1: With mode 3'b000 (clamp) and an exact result that fits in W bits, the result equals the exact sum or difference.
- R2: With mode 3'b000 and an exact result that does not fit in W bits, the result is +(2^(W-1)-1) when the exact result is positive and -2^(W-1) when it is negative.
- R3: With mode 3'b001 (widen), the result is the exact W+1-bit sum or difference, and round_en has no effect.
- R4: With mode 3'b010 (halve) and round_en=0, the result is the exact value shifted right by one bit and rounded toward minus infinity.
- R5: When a halving mode has round_en=1, half an output LSB is added before the bit is dropped. If that increment would go past +(2^(W-1)-1), the result stays at +(2^(W-1)-1).
- R6: With mode 3'b011 (block float), the result is the unshifted exact value when it fits in W bits. Otherwise it is the halved value under the R4/R5 rules.
- R7: exp_inc is 1 exactly when mode 3'b011 applied the halving shift, and 0 in every other case.
- R8: With mode 3'b100 (wrap), the result is the exact value reduced modulo 2^W into [-2^(W-1), 2^(W-1)).
- R9: sub_en=1 computes op_a - op_b, and every mode applies the same rules to the difference as it does to a sum.
- R10: ovf is 1 exactly when the exact result does not fit in W bits, whatever the mode.
- R11: Outputs are registered with one cycle of latency. A synchronous active-low reset clears result, ovf and exp_inc to zero.
- R12: The unused mode codes 3'b101, 3'b110 and 3'b111 behave as wrap.
- R13: In every mode except widen, result bit W equals result bit W-1 (sign extension).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | W | First operand, signed fraction |
| op_b | input | W | Second operand, signed fraction |
| sub_en | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| mode_sel | input | 3 | Overflow mode: 0 clamp, 1 widen, 2 halve, 3 block float, 4 to 7 wrap |
| round_en | input | 1 | 1 = round the dropped bit, 0 = truncate |
| result | output | W+1 | Registered result, sign-extended when narrow |
| ovf | output | 1 | Registered flag: exact result does not fit in W bits |
| exp_inc | output | 1 | Registered flag: block-float mode shifted right |

## Verification
The corner the bench pushes hardest is rounding at the top of the range. The largest positive value minus the most negative one, halved with rounding, must stay at the positive maximum. A design that lets that increment wrap would return the most negative value instead. Negative odd results are halved both ways to catch an arithmetic shift that rounds toward zero, or a shift that fills with zeros. Clamping is checked in both directions to catch a swapped limit. The block-float mode is run just below and just above the overflow edge, to catch a flag or shift that fires one value too early. Subtraction of the most negative operand, the reserved mode codes and round_en under widen and wrap catch a decoder or carry path that handles only the common case.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [2:0] {
        MODE_CLAMP = 3'd0,
        MODE_WIDEN = 3'd1,
        MODE_HALVE = 3'd2,
        MODE_BFLT  = 3'd3,
        MODE_WRAP  = 3'd4
    } fxp_mode_e;

endpackage

// File: rtl/fxp_exact_sum.sv
// Exact W+1-bit add/subtract with an out-of-range indication for W bits.
module fxp_exact_sum #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W:0]   sum,
    output logic         wide
);
    logic [W:0] a_x;
    logic [W:0] b_x;

    always_comb begin
        a_x  = {a[W-1], a};
        b_x  = {b[W-1], b};
        sum  = sub ? (a_x - b_x) : (a_x + b_x);
        wide = sum[W] ^ sum[W-1];
    end
endmodule

// File: rtl/fxp_halver.sv
// Divide a W+1-bit value by two into W bits, truncating or rounding.
module fxp_halver #(
    parameter int W = 8
) (
    input  logic [W:0]   sum,
    input  logic         rnd,
    output logic [W-1:0] half
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] floor_v;

    always_comb begin
        floor_v = sum[W:1];
        if (rnd && sum[0]) begin
            half = (floor_v == POS_MAX) ? POS_MAX : floor_v + 1'b1;
        end else begin
            half = floor_v;
        end
    end
endmodule

// File: rtl/fxp_clamp.sv
// Limit a W+1-bit value to the W-bit signed range.
module fxp_clamp #(
    parameter int W = 8
) (
    input  logic [W:0]   sum,
    output logic [W-1:0] sat
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        unique case ({sum[W], sum[W-1]})
            2'b01:   sat = POS_MAX;
            2'b10:   sat = NEG_MIN;
            default: sat = sum[W-1:0];
        endcase
    end
endmodule

// File: rtl/fxp_addsub.sv
module fxp_addsub
    import fxp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_en,
    input  logic [2:0]   mode_sel,
    input  logic         round_en,
    output logic [W:0]   result,
    output logic         ovf,
    output logic         exp_inc
);
    localparam int OW = W + 1;
    localparam logic [OW-1:0] POS_MAX_X = OW'((1 << (W-1)) - 1);
    localparam logic [OW-1:0] NEG_MIN_X = ~POS_MAX_X;

    logic [W:0]    exact;
    logic          wide;
    logic [W-1:0]  halved;
    logic [W-1:0]  clamped;
    fxp_mode_e     mode;
    logic [OW-1:0] res_d;
    logic          inc_d;
    logic [OW-1:0] res_q;
    logic          ovf_q;
    logic          inc_q;

    fxp_exact_sum #(.W(W)) u_sum (
        .a(op_a), .b(op_b), .sub(sub_en), .sum(exact), .wide(wide)
    );

    fxp_halver #(.W(W)) u_half (
        .sum(exact), .rnd(round_en), .half(halved)
    );

    fxp_clamp #(.W(W)) u_clamp (
        .sum(exact), .sat(clamped)
    );

    always_comb begin
        mode  = (mode_sel > 3'd4) ? MODE_WRAP : fxp_mode_e'(mode_sel);
        inc_d = 1'b0;
        unique case (mode)
            MODE_CLAMP: res_d = {clamped[W-1], clamped};
            MODE_WIDEN: res_d = exact;
            MODE_HALVE: res_d = {halved[W-1], halved};
            MODE_BFLT: begin
                if (wide) begin
                    res_d = {halved[W-1], halved};
                    inc_d = 1'b1;
                end else begin
                    res_d = {exact[W-1], exact[W-1:0]};
                end
            end
            default:    res_d = {exact[W-1], exact[W-1:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ovf_q <= 1'b0;
            inc_q <= 1'b0;
        end else begin
            res_q <= res_d;
            ovf_q <= wide;
            inc_q <= inc_d;
        end
    end

    assign result  = res_q;
    assign ovf     = ovf_q;
    assign exp_inc = inc_q;

    // Reset clears all outputs on the next edge (R11)
    p_reset_clears_r11: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !ovf && !exp_inc));

    // Clamp mode with overflow lands exactly on a range limit (R2)
    p_clamp_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == 3'd0 && ovf)
            |-> (result == POS_MAX_X || result == NEG_MIN_X));

    // Exponent flag only follows a block-float overflow (R7)
    p_inc_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_inc |-> (ovf && $past(mode_sel) == 3'd3));

    // Widen mode reproduces the exact arithmetic on the operands (R3)
    p_widen_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == 3'd1)
            |-> (result == ($past(sub_en)
                 ? ({$past(op_a[W-1]), $past(op_a)} - {$past(op_b[W-1]), $past(op_b)})
                 : ({$past(op_a[W-1]), $past(op_a)} + {$past(op_b[W-1]), $past(op_b)}))));

    // Narrow modes keep the result sign-extended (R13)
    p_sign_ext_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) != 3'd1) |-> (result[W] == result[W-1]));
endmodule

// File: tb/fxp_addsub_test.sv
module fxp_addsub_test;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam int MINV = -(1 << (W-1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_en = 1'b0;
    logic [2:0]   mode_sel = 3'd0;
    logic         round_en = 1'b0;
    logic [W:0]   result;
    logic         ovf;
    logic         exp_inc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxp_addsub #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
        .mode_sel(mode_sel), .round_en(round_en),
        .result(result), .ovf(ovf), .exp_inc(exp_inc)
    );

    function automatic int floor_half(int v);
        return (v >= 0) ? v / 2 : -((-v + 1) / 2);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(int a, int b, bit s, int m, bit r, string req);
        int e;
        int h;
        int x;
        bit o;
        bit inc;
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); sub_en = s; mode_sel = 3'(m); round_en = r;
        e = s ? a - b : a + b;
        o = (e > MAXV) || (e < MINV);
        h = r ? floor_half(e + 1) : floor_half(e);
        if (h > MAXV) h = MAXV;
        inc = 0;
        case (m)
            0: x = (e > MAXV) ? MAXV : ((e < MINV) ? MINV : e);
            1: x = e;
            2: x = h;
            3: begin x = o ? h : e; inc = o; end
            default: begin
                x = e;
                if (x > MAXV) x -= (1 << W);
                if (x < MINV) x += (1 << W);
            end
        endcase
        @(negedge clk);
        check(req, "result", int'($signed(result)), x);
        check({req, "/R10"}, "ovf", int'(ovf), int'(o));
        check({req, "/R7"}, "exp_inc", int'(exp_inc), int'(inc));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; op_a = 8'd100; op_b = 8'd100; mode_sel = 3'd3;
        @(negedge clk);
        check("R11", "reset result", int'(result), 0);
        check("R11", "reset ovf", int'(ovf), 0);
        check("R11", "reset exp_inc", int'(exp_inc), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_clamp();
        run_op(20, -35, 0, 0, 0, "R1");
        run_op(100, 50, 0, 0, 1, "R2");
        run_op(-100, -50, 0, 0, 0, "R2");
    endtask

    task automatic t_widen();
        run_op(127, 127, 0, 1, 0, "R3");
        run_op(-128, -128, 0, 1, 1, "R3");
        run_op(-3, 6, 0, 1, 1, "R3");
    endtask

    task automatic t_halve();
        run_op(5, 2, 0, 2, 0, "R4");
        run_op(-5, -2, 0, 2, 0, "R4");
        run_op(5, 2, 0, 2, 1, "R5");
        run_op(-5, -2, 0, 2, 1, "R5");
    endtask

    task automatic t_round_top();
        run_op(127, -128, 1, 2, 1, "R5");
        run_op(127, -128, 1, 2, 0, "R5");
        run_op(127, -128, 1, 3, 1, "R5");
    endtask

    task automatic t_bflt();
        run_op(10, 20, 0, 3, 1, "R6");
        run_op(64, 63, 0, 3, 1, "R6");
        run_op(64, 64, 0, 3, 0, "R6");
        run_op(100, 101, 0, 3, 0, "R6");
        run_op(100, 101, 0, 3, 1, "R6");
        run_op(-100, -29, 0, 3, 0, "R6");
    endtask

    task automatic t_wrap();
        run_op(100, 100, 0, 4, 0, "R8");
        run_op(-128, -1, 0, 4, 1, "R8");
        run_op(30, 40, 0, 4, 1, "R8");
    endtask

    task automatic t_subtract();
        run_op(-128, 1, 1, 0, 0, "R9");
        run_op(10, -128, 1, 0, 0, "R9");
        run_op(0, -128, 1, 1, 0, "R9");
        run_op(-128, 127, 1, 2, 0, "R9");
        run_op(-128, 1, 1, 3, 0, "R9");
        run_op(-128, 1, 1, 4, 0, "R9");
    endtask

    task automatic t_reserved();
        run_op(100, 100, 0, 5, 0, "R12");
        run_op(-90, -90, 0, 6, 1, "R12");
        run_op(3, 4, 1, 7, 0, "R12");
    endtask

    task automatic t_narrow_sign();
        run_op(-1, 0, 0, 0, 0, "R13");
        run_op(-64, -64, 0, 4, 0, "R13");
        check("R13", "sign extension", int'(result[W]), int'(result[W-1]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_clamp();
        t_widen();
        t_halve();
        t_round_top();
        t_bflt();
        t_wrap();
        t_subtract();
        t_reserved();
        t_narrow_sign();
        t_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule